// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This unit sits beside the execute stage of a RISC core and performs integer multiplication and division on two W-bit operands (W = 32 by default). A request carries an operation code and two operands. It is transferred on a valid/ready handshake: the producer holds `in_valid` and the operands steady until it samples `in_ready` high at a rising edge. The unit pushes back only by dropping `in_ready`, which it does while it works on the second half of a wide product or while a division is running. Results go into a 2W-bit accumulator made of a high half and a low half. The targeted multiply instead returns its low word on a register-file write strobe.

Multiplication uses one W × W/2 signed array. If the second operand fits in W/2 bits, one pass gives the whole product, so a new multiply can enter on every clock. A wider operand needs a second pass through the same array, which makes ready low for one cycle. Division is restoring and takes one quotient bit per clock. Before it starts, it skips the leading all-zero groups of G bits in the dividend magnitude, so a short dividend finishes sooner. The accumulator can be read or written directly through plain ports. An access that collides with pending work raises a stall flag.

Top module: `mdu_iter`

## Requirements
- R1: A request is taken at a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when no operation is pending. It is low in the cycle after a wide multiply is taken and for the whole of a division.
- R2: A multiply-class request whose second operand is narrow finishes at its accepting edge. For signed codes, narrow means bits W-1..W/2 all equal bit W/2-1. For unsigned codes, it means those bits are all zero. `done` is high in the following cycle and `in_ready` stays high, so such requests can be taken on consecutive edges.
- R3: A multiply-class request with a wide second operand finishes one edge after acceptance: `done` is high in the cycle after that second edge and `in_ready` is low in between.
- R4: Code 0 (signed) and code 1 (unsigned) replace {hi, lo} with the full 2W-bit product of `in_a` and `in_b`.
- R5: Codes 2 (signed) and 3 (unsigned) add the 2W-bit product to {hi, lo}. Codes 4 (signed) and 5 (unsigned) subtract it. Both wrap modulo 2^(2W).
- R6: Code 6 forms the signed product and pulses `res_we` together with `done`, with `res_data` equal to the low W bits. hi and lo are left unchanged.
- R7: Code 7 (signed) and code 8 (unsigned) divide `in_a` by `in_b`. lo receives the quotient truncated toward zero and hi receives the remainder, which has the sign of the dividend. The most negative dividend divided by -1 gives a quotient equal to that same most negative value and a remainder of 0.
- R8: Let k be the number of leading G-bit groups that are all zero in the dividend magnitude, capped at W/G-1, and let N = W - k*G. A division taken at edge 0 raises `done` in the cycle after edge N+1, and `busy` stays high until then.
- R9: A division by zero finishes with the same latency as any other division and does not trap. The contents of hi and lo afterwards are not defined.
- R10: `acc_stall` is high whenever `acc_rd_req` is high while an operation is pending, and low for a read when nothing is pending.
- R11: An accumulator write (`acc_wr_en`) loads hi and lo at the next edge only in a cycle with nothing pending and `in_valid` low. In any other cycle `acc_stall` is high and the write is dropped.
- R12: After reset, hi and lo are zero, `busy`, `done` and `res_we` are low and `in_ready` is high. `done` pulses once for each completed request. Codes 9 to 15 follow multiply timing and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | W | First operand / dividend |
| in_b | input | W | Second operand / divisor |
| busy | output | 1 | An operation is pending |
| done | output | 1 | One-cycle completion pulse |
| res_we | output | 1 | Register-file write strobe for code 6 |
| res_data | output | W | Low word of the code-6 product |
| hi | output | W | High half of the accumulator |
| lo | output | W | Low half of the accumulator |
| acc_rd_req | input | 1 | Core wants to read hi/lo |
| acc_wr_en | input | 1 | Core writes hi/lo |
| acc_wr_hi | input | W | Data for hi |
| acc_wr_lo | input | W | Data for lo |
| acc_stall | output | 1 | Accumulator access must wait |

## Verification
The hardest case to reach from the ports is overlap: an accumulator write or read that arrives while a division is still running, and a write that lands in the same cycle a new request is offered. The bench builds both by hand. It starts a long division, raises read and write requests in the cycle after acceptance, and holds them until completion to show that the stall is raised and the write is lost. It then offers a targeted multiply together with a write. Running at W = 16 with G = 4 makes every early-in length from 4 to 16 iterations reachable. The bench also sweeps a set of edge operands: zero, ones, the boundaries of the narrow range, and the most negative value against -1.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_MADD  = 4'd2,
    OP_MADDU = 4'd3,
    OP_MSUB  = 4'd4,
    OP_MSUBU = 4'd5,
    OP_MUL   = 4'd6,
    OP_DIV   = 4'd7,
    OP_DIVU  = 4'd8
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL2,
    ST_DIV
  } mdu_st_e;

  typedef enum logic [1:0] {
    ACC_SET,
    ACC_ADD,
    ACC_SUB,
    ACC_KEEP
  } acc_mode_e;

  function automatic logic op_signed(mdu_op_e op);
    case (op)
      OP_MULT, OP_MADD, OP_MSUB, OP_MUL, OP_DIV: return 1'b1;
      default:                                   return 1'b0;
    endcase
  endfunction

  function automatic logic op_divide(mdu_op_e op);
    return (op == OP_DIV) || (op == OP_DIVU);
  endfunction

  function automatic acc_mode_e op_acc_mode(mdu_op_e op);
    case (op)
      OP_MULT, OP_MULTU: return ACC_SET;
      OP_MADD, OP_MADDU: return ACC_ADD;
      OP_MSUB, OP_MSUBU: return ACC_SUB;
      default:           return ACC_KEEP;
    endcase
  endfunction

endpackage

// File: rtl/mdu_mul_array.sv
// One W x H signed array; each operand can be presented as signed or unsigned.
module mdu_mul_array #(
  parameter int W = 32,
  parameter int H = W / 2
) (
  input  logic [W-1:0]   a_i,
  input  logic           a_sgn_i,
  input  logic [H-1:0]   b_i,
  input  logic           b_sgn_i,
  output logic [2*W-1:0] p_o
);
  localparam int PW  = W + H + 2;
  localparam int EXT = 2 * W - PW;

  logic signed [W:0]    ax;
  logic signed [H:0]    bx;
  logic signed [PW-1:0] px;

  always_comb begin
    ax  = {a_sgn_i & a_i[W-1], a_i};
    bx  = {b_sgn_i & b_i[H-1], b_i};
    px  = ax * bx;
    p_o = {{EXT{px[PW-1]}}, px};
  end
endmodule

// File: rtl/mdu_lead_skip.sv
// Counts leading all-zero G-bit groups of the dividend magnitude (capped so
// at least one group is always processed) and derives the iteration count.
module mdu_lead_skip #(
  parameter int W = 32,
  parameter int G = 8,
  localparam int NG   = W / G,
  localparam int CNTW = $clog2(W + 1),
  localparam int SW   = $clog2(W)
) (
  input  logic [W-1:0]    mag_i,
  output logic [SW-1:0]   skip_o,
  output logic [CNTW-1:0] iters_o
);
  logic [NG-2:0] grp_zero;

  for (genvar g = 0; g < NG - 1; g++) begin : g_grp
    assign grp_zero[g] = ~|mag_i[W-1-g*G -: G];
  end

  always_comb begin
    int  k;
    logic run;
    k   = 0;
    run = 1'b1;
    for (int g = 0; g < NG - 1; g++) begin
      if (run && grp_zero[g]) k = k + 1;
      else                    run = 1'b0;
    end
    skip_o  = SW'(k * G);
    iters_o = CNTW'(W - k * G);
  end
endmodule

// File: rtl/mdu_div.sv
// Restoring divider, one quotient bit per clock, with an early-in skip.
module mdu_div #(
  parameter int W = 32,
  parameter int G = 8,
  localparam int CNTW = $clog2(W + 1),
  localparam int SW   = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o
);
  logic [W-1:0]    quo_q, rem_q, dvs_q;
  logic [CNTW-1:0] cnt_q;
  logic            neg_q_q, neg_r_q, busy_q;

  logic [W-1:0]    mag_a, mag_b;
  logic [SW-1:0]   skip;
  logic [CNTW-1:0] iters;
  logic [W:0]      trial, diff;
  logic            fits;

  always_comb begin
    mag_a = (sgn_i && a_i[W-1]) ? -a_i : a_i;
    mag_b = (sgn_i && b_i[W-1]) ? -b_i : b_i;
  end

  mdu_lead_skip #(.W(W), .G(G)) u_lead (
    .mag_i  (mag_a),
    .skip_o (skip),
    .iters_o(iters)
  );

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = ~diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (start_i) begin
      quo_q   <= mag_a << skip;
      rem_q   <= '0;
      dvs_q   <= mag_b;
      cnt_q   <= iters;
      neg_q_q <= sgn_i & (a_i[W-1] ^ b_i[W-1]);
      neg_r_q <= sgn_i & a_i[W-1];
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == '0);
  assign q_o    = neg_q_q ? -quo_q : quo_q;
  assign r_o    = neg_r_q ? -rem_q : rem_q;

  AST_DIV_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R1
  AST_DIV_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o); // R12
  AST_DIV_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CNTW'(W))); // R8
  AST_DIV_FIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && !start_i) |=> !busy_q); // R8
endmodule

// File: rtl/mdu_iter.sv
module mdu_iter
  import mdu_pkg::*;
#(
  parameter int W = 32,
  parameter int G = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         busy,
  output logic         done,
  output logic         res_we,
  output logic [W-1:0] res_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  input  logic         acc_rd_req,
  input  logic         acc_wr_en,
  input  logic [W-1:0] acc_wr_hi,
  input  logic [W-1:0] acc_wr_lo,
  output logic         acc_stall
);
  localparam int H = W / 2;

  mdu_st_e        state_q;
  mdu_op_e        op_q;
  logic [W-1:0]   a_q;
  logic [H-1:0]   bhi_q;
  logic           sgn_q;
  logic [2*W-1:0] part_q;
  logic [W-1:0]   hi_q, lo_q, res_q;
  logic           done_q, res_we_q;

  mdu_op_e        op_in, op_cur;
  logic           sgn_in, is_div_in, narrow_in, accept;
  logic [W-1:0]   arr_a;
  logic           arr_as, arr_bs;
  logic [H-1:0]   arr_b;
  logic [2*W-1:0] arr_p, prod, acc_new, acc_base;
  logic           mul_fin, wr_apply;
  logic           div_busy, div_fin;
  logic [W-1:0]   div_q, div_r;

  // request decode and handshake
  always_comb begin
    op_in     = mdu_op_e'(in_op);
    sgn_in    = op_signed(op_in);
    is_div_in = op_divide(op_in);
    narrow_in = sgn_in ? (in_b[W-1:H] == {H{in_b[H-1]}}) : (in_b[W-1:H] == '0);
    in_ready  = (state_q == ST_IDLE);
    accept    = in_valid && in_ready;
  end

  // shared array: first pass from the ports, second pass from the held request
  always_comb begin
    if (state_q == ST_MUL2) begin
      arr_a  = a_q;
      arr_as = sgn_q;
      arr_b  = bhi_q;
      arr_bs = sgn_q;
      op_cur = op_q;
    end else begin
      arr_a  = in_a;
      arr_as = sgn_in;
      arr_b  = in_b[H-1:0];
      arr_bs = sgn_in & narrow_in;
      op_cur = op_in;
    end
  end

  mdu_mul_array #(.W(W), .H(H)) u_arr (
    .a_i    (arr_a),
    .a_sgn_i(arr_as),
    .b_i    (arr_b),
    .b_sgn_i(arr_bs),
    .p_o    (arr_p)
  );

  always_comb begin
    acc_base = {hi_q, lo_q};
    prod     = (state_q == ST_MUL2) ? (part_q + (arr_p << H)) : arr_p;
    case (op_acc_mode(op_cur))
      ACC_SET: acc_new = prod;
      ACC_ADD: acc_new = acc_base + prod;
      ACC_SUB: acc_new = acc_base - prod;
      default: acc_new = acc_base;
    endcase
    mul_fin  = (accept && !is_div_in && narrow_in) || (state_q == ST_MUL2);
    wr_apply = acc_wr_en && (state_q == ST_IDLE) && !in_valid;
  end

  mdu_div #(.W(W), .G(G)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(accept && is_div_in),
    .sgn_i  (op_in == OP_DIV),
    .a_i    (in_a),
    .b_i    (in_b),
    .busy_o (div_busy),
    .fin_o  (div_fin),
    .q_o    (div_q),
    .r_o    (div_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_MULT;
      a_q      <= '0;
      bhi_q    <= '0;
      sgn_q    <= 1'b0;
      part_q   <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      res_q    <= '0;
      done_q   <= 1'b0;
      res_we_q <= 1'b0;
    end else begin
      done_q   <= mul_fin || div_fin;
      res_we_q <= mul_fin && (op_cur == OP_MUL);
      if (mul_fin && (op_cur == OP_MUL)) res_q <= prod[W-1:0];

      if (mul_fin) begin
        hi_q <= acc_new[2*W-1:W];
        lo_q <= acc_new[W-1:0];
      end else if (div_fin) begin
        hi_q <= div_r;
        lo_q <= div_q;
      end else if (wr_apply) begin
        hi_q <= acc_wr_hi;
        lo_q <= acc_wr_lo;
      end

      case (state_q)
        ST_IDLE: begin
          if (accept && is_div_in) begin
            state_q <= ST_DIV;
          end else if (accept && !narrow_in) begin
            state_q <= ST_MUL2;
            op_q    <= op_in;
            a_q     <= in_a;
            bhi_q   <= in_b[W-1:H];
            sgn_q   <= sgn_in;
            part_q  <= arr_p;
          end
        end
        ST_MUL2: state_q <= ST_IDLE;
        default: if (div_fin) state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign res_we    = res_we_q;
  assign res_data  = res_q;
  assign hi        = hi_q;
  assign lo        = lo_q;
  assign acc_stall = ((acc_rd_req || acc_wr_en) && busy) || (acc_wr_en && in_valid);

  AST_NARROW_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_div_in && narrow_in) |=> (done && in_ready)); // R2
  AST_WIDE_ONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_div_in && !narrow_in) |=> (!in_ready && !done)); // R3
  AST_DIV_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !in_ready); // R1
  AST_MUL_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (hi == $past(hi) && lo == $past(lo))); // R6
  AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd_req && div_busy) |-> acc_stall); // R10
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_en && in_valid) |-> acc_stall); // R11
endmodule

// File: tb/mdu_iter_tb.sv
module mdu_iter_tb;
  localparam int W = 16;
  localparam int G = 4;

  localparam logic [3:0] C_MULT = 4'd0, C_MULTU = 4'd1, C_MADD = 4'd2, C_MADDU = 4'd3,
                         C_MSUB = 4'd4, C_MSUBU = 4'd5, C_MUL = 4'd6, C_DIV = 4'd7,
                         C_DIVU = 4'd8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         busy, done, res_we;
  logic [W-1:0] res_data, hi, lo;
  logic         acc_rd_req = 1'b0, acc_wr_en = 1'b0;
  logic [W-1:0] acc_wr_hi = '0, acc_wr_lo = '0;
  logic         acc_stall;

  int n_chk = 0;
  int n_fail = 0;
  logic [2*W-1:0] model;

  always #2 clk = ~clk;

  mdu_iter #(.W(W), .G(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .busy(busy), .done(done),
    .res_we(res_we), .res_data(res_data), .hi(hi), .lo(lo),
    .acc_rd_req(acc_rd_req), .acc_wr_en(acc_wr_en), .acc_wr_hi(acc_wr_hi),
    .acc_wr_lo(acc_wr_lo), .acc_stall(acc_stall)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_signed_op(input logic [3:0] op);
    return op == C_MULT || op == C_MADD || op == C_MSUB || op == C_MUL || op == C_DIV;
  endfunction

  function automatic bit is_narrow(input bit sgn, input logic [W-1:0] b);
    int sb;
    sb = $signed(b);
    return sgn ? (sb >= -128 && sb <= 127) : (b < 16'd256);
  endfunction

  function automatic int div_lat(input bit sgn, input logic [W-1:0] a);
    logic [W-1:0] m;
    int lz, k;
    m  = (sgn && a[W-1]) ? -a : a;
    lz = 0;
    for (int i = W - 1; i >= 0 && m[i] == 1'b0; i--) lz++;
    k = lz / G;
    if (k > W / G - 1) k = W / G - 1;
    return (W - k * G) + 1;
  endfunction

  task automatic wr_acc(input logic [2*W-1:0] v);
    acc_wr_en = 1'b1;
    acc_wr_hi = v[2*W-1:W];
    acc_wr_lo = v[W-1:0];
    @(posedge clk);
    @(negedge clk);
    acc_wr_en = 1'b0;
    model = v;
    check({hi, lo} == v, "R11", "idle write", {hi, lo}, v);
  endtask

  task automatic run_op(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    bit sgn, dv, nar, rdy1;
    int lat, exp_lat;
    longint pa, pb;
    logic [2*W-1:0] p, exp_acc;
    int sa, sb, q, r;
    string tag;
    sgn = is_signed_op(op);
    dv  = (op == C_DIV) || (op == C_DIVU);
    nar = is_narrow(sgn, b);
    pa  = sgn ? longint'($signed(a)) : longint'(a);
    pb  = sgn ? longint'($signed(b)) : longint'(b);
    p   = 32'(pa * pb);
    exp_acc = model;
    case (op)
      C_MULT, C_MULTU: exp_acc = p;
      C_MADD, C_MADDU: exp_acc = model + p;
      C_MSUB, C_MSUBU: exp_acc = model - p;
      C_DIV, C_DIVU: begin
        sa = sgn ? int'($signed(a)) : int'(a);
        sb = sgn ? int'($signed(b)) : int'(b);
        if (sb != 0) begin
          q = sa / sb;
          r = sa % sb;
          exp_acc = {16'(r), 16'(q)};
        end
      end
      default: exp_acc = model;
    endcase
    exp_lat = dv ? div_lat(sgn, a) : (nar ? 0 : 1);

    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rdy1 = in_ready;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end

    check(rdy1 == (!dv && nar), "R1", "ready after accept", rdy1, (!dv && nar));
    tag = dv ? ((b == 0) ? "R9" : "R8") : (nar ? "R2" : "R3");
    check(lat == exp_lat, tag, "latency", lat, exp_lat);
    if (dv && b == 0) begin
      model = {hi, lo};
    end else begin
      case (op)
        C_MULT, C_MULTU:                  tag = "R4";
        C_MADD, C_MADDU, C_MSUB, C_MSUBU: tag = "R5";
        C_MUL:                            tag = "R6";
        C_DIV, C_DIVU:                    tag = "R7";
        default:                          tag = "R12";
      endcase
      check({hi, lo} == exp_acc, tag, "hi/lo", {hi, lo}, exp_acc);
      model = exp_acc;
    end
    check(res_we == (op == C_MUL), "R6", "res_we", res_we, (op == C_MUL));
    if (op == C_MUL) check(res_data == p[W-1:0], "R6", "res_data", res_data, p[W-1:0]);
  endtask

  logic [W-1:0] vals [18] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0007, 16'h007F,
                              16'h0080, 16'h00FF, 16'h0100, 16'h1234, 16'h7FFF, 16'h8000,
                              16'h8001, 16'hFF80, 16'hFFFF, 16'hFFFE, 16'h00C3, 16'h5A5A};
  logic [3:0] swp_ops [5] = '{C_MULT, C_MULTU, C_MUL, C_DIV, C_DIVU};
  logic [3:0] acc_ops [4] = '{C_MADD, C_MADDU, C_MSUB, C_MSUBU};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(in_ready == 1'b1 && busy == 1'b0, "R12", "reset ready/busy", {in_ready, busy}, 2'b10);
    check(done == 1'b0 && res_we == 1'b0, "R12", "reset done/res_we", {done, res_we}, 0);
    check({hi, lo} == '0, "R12", "reset hi/lo", {hi, lo}, 0);

    // R4 R6 R7 R8 R9 sweep with a fresh preset each time
    for (int o = 0; o < 5; o++)
      for (int i = 0; i < 18; i++)
        for (int j = 0; j < 18; j++) begin
          wr_acc({vals[j] ^ 16'hA5C3, vals[i] ^ 16'h3C5A});
          run_op(swp_ops[o], vals[i], vals[j]);
        end

    // R5 accumulate chains
    for (int o = 0; o < 4; o++) begin
      wr_acc(32'h1357_9BDF);
      for (int i = 0; i < 18; i++)
        for (int j = 0; j < 18; j++) run_op(acc_ops[o], vals[i], vals[j]);
    end

    // R2 narrow multiply-adds on consecutive edges
    wr_acc(32'h0000_0100);
    begin
      logic [W-1:0] xa [4] = '{16'd3, 16'hFFFE, 16'd127, 16'd5};
      logic [W-1:0] xb [4] = '{16'd4, 16'd100, 16'hFF80, 16'd5};
      in_valid = 1'b1; in_op = C_MADD; in_a = xa[0]; in_b = xb[0];
      for (int k = 0; k < 4; k++) begin
        @(posedge clk);
        @(negedge clk);
        model = model + 32'(longint'($signed(xa[k])) * longint'($signed(xb[k])));
        check(done && in_ready, "R2", "back-to-back done/ready", {done, in_ready}, 2'b11);
        if (k < 3) begin in_a = xa[k+1]; in_b = xb[k+1]; end
        else in_valid = 1'b0;
      end
      check({hi, lo} == model, "R5", "chained hi/lo", {hi, lo}, model);
    end

    // R3 two wide multiplies with valid held
    in_valid = 1'b1; in_op = C_MULT; in_a = 16'h1234; in_b = 16'h4321;
    @(posedge clk); @(negedge clk);
    check(!in_ready && !done, "R3", "gap after wide", {in_ready, done}, 0);
    @(posedge clk); @(negedge clk);
    check(done && in_ready, "R3", "wide finish", {done, in_ready}, 2'b11);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R3", "second wide gap", in_ready, 0);
    @(negedge clk);
    check(done && {hi, lo} == 32'h04C5_F4B4, "R4", "wide product", {hi, lo}, 32'h04C5_F4B4);

    // R10 R11 accesses during a divide
    in_valid = 1'b1; in_op = C_DIV; in_a = 16'h7000; in_b = 16'd3;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    acc_rd_req = 1'b1; acc_wr_en = 1'b1; acc_wr_hi = 16'hDEAD; acc_wr_lo = 16'hBEEF;
    #1;
    check(acc_stall, "R10", "read stall while dividing", acc_stall, 1);
    while (!done) @(negedge clk);
    check({hi, lo} == 32'h0001_2555, "R11", "write dropped during divide", {hi, lo}, 32'h0001_2555);
    acc_wr_en = 1'b0;
    #1;
    check(!acc_stall, "R10", "read idle no stall", acc_stall, 0);
    acc_rd_req = 1'b0;
    @(negedge clk);

    // R11 write offered with a request
    in_valid = 1'b1; in_op = C_MUL; in_a = 16'd3; in_b = 16'd5;
    acc_wr_en = 1'b1; acc_wr_hi = 16'h1111; acc_wr_lo = 16'h2222;
    #1;
    check(acc_stall, "R11", "write with request stalls", acc_stall, 1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; acc_wr_en = 1'b0;
    check({hi, lo} == 32'h0001_2555, "R11", "write with request dropped", {hi, lo}, 32'h0001_2555);
    check(res_we && res_data == 16'd15, "R6", "targeted result", res_data, 15);

    // R12 unused code and R7 overflow corner
    model = {hi, lo};
    run_op(4'd9, 16'h1234, 16'h0011);
    run_op(4'd12, 16'h1234, 16'h4011);
    run_op(C_DIV, 16'h8000, 16'hFFFF);
    @(negedge clk);
    check(!done, "R12", "done single pulse", done, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule